// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port

This block is an eight-line general purpose port in which every line serves as an input or as an output on its own, and there is no direction register. Each line has one output latch bit. When the bit holds 0, a strong pulldown pulls the pad low. When the bit holds 1, the pad is held high only by a weak pullup, so an outside device can still pull the line low. This is how a line works as an input. To make a rising edge fast, a newly written 1 also turns on a strong pullup for a short, counted number of clock cycles.

The latch is changed by three operations on a small command port. The first loads the whole latch. The second ANDs the latch with a mask, which clears selected lines. The third ORs the latch with a mask, which sets selected lines. The read path never returns the latch. It returns the pad levels after a synchroniser, so a line whose latch holds 0 reads back as 0. The pad itself lies outside the block: the block only produces three drive enables per line (strong low, strong high pulse, weak high), and the pad electronics combine them.

Top module: `qb_port`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) sets every latch bit to 1. After reset drv_weak is all ones, drv_low is all zeros, drv_high is all zeros, and every synchroniser stage holds all ones.
- R2: op_code 2'b01 (load) writes op_mask into the latch at the clock edge. From the next cycle on, each bit's drv_weak equals its latch bit and its drv_low equals the inverse of that bit.
- R3: A bit that is started on the strong pullup raises drv_high in the cycle after the operation. drv_high then stays high for exactly PULSE_CYCLES cycles and falls, and the bit is left on the weak pullup only.
- R4: Loading a 1 into a bit whose latch already holds 1, including while its pulse is still running, restarts the pulse for a full PULSE_CYCLES cycles.
- R5: A bit whose latch becomes 0 drops drv_high in that same cycle. drv_low and drv_high are never both high on any bit.
- R6: op_code 2'b10 (and) sets the latch to latch AND op_mask and never starts a strong pullup pulse.
- R7: op_code 2'b11 (or) sets the latch to latch OR op_mask. It starts a pulse on every bit whose mask bit is 1, and on no other bit.
- R8: rd_data equals pin_in delayed by SYNC_STAGES clock edges (default 2), bit for bit. It does not depend on the latch contents.
- R9: op_code 2'b00 (idle) leaves the latch unchanged for any op_mask. A pulse that is already running keeps counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 2 | 00 idle, 01 load, 10 and, 11 or |
| op_mask | input | WIDTH | Data or mask for the operation |
| pin_in | input | WIDTH | Pad levels as seen at the pads |
| rd_data | output | WIDTH | Synchronised pad levels |
| drv_low | output | WIDTH | Strong pulldown enable per line |
| drv_high | output | WIDTH | Strong pullup pulse enable per line |
| drv_weak | output | WIDTH | Weak pullup enable per line (equals the latch) |

## Verification
The bench models each pad as the wired-AND of an outside driver and the block's own pulldown. It checks that a line latched at 1 reads back an outside 0, and that a line latched at 0 reads 0 whatever the outside driver does. An off-by-one pulse counter would hold drv_high for one cycle too many or too few. A missing retrigger would end a rewritten pulse early, and an AND that fires the pulse would raise drv_high on lines that were only being kept. A design that did not cancel the pulse on a 0 write would drive both strong devices at once. Random mixes of operations, masks and outside levels are compared, cycle by cycle, against a reference model in the bench.

// File: rtl/qbport_pkg.sv
package qbport_pkg;
  typedef enum logic [1:0] {
    QB_NOP  = 2'b00,
    QB_LOAD = 2'b01,
    QB_ANDM = 2'b10,
    QB_ORM  = 2'b11
  } qb_op_e;
endpackage

// File: rtl/qb_pin_sync.sv
module qb_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '1;
    else     st[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[k] <= '1;
      else     st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/qb_bit_cell.sv
module qb_bit_cell
  import qbport_pkg::*;
#(
  parameter int PULSE_CYCLES = 25,
  localparam int CW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  qb_op_e op,
  input  logic   mask,
  output logic   lat,
  output logic   hi
);
  logic          lat_q, hi_q, nl, fire;
  logic [CW-1:0] cnt_q;

  always_comb begin
    unique case (op)
      QB_LOAD: nl = mask;
      QB_ANDM: nl = lat_q & mask;
      QB_ORM:  nl = lat_q | mask;
      default: nl = lat_q;
    endcase
    fire = nl && (!lat_q || ((op == QB_LOAD || op == QB_ORM) && mask));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= 1'b1;
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      lat_q <= nl;
      if (!nl) begin
        cnt_q <= '0;
        hi_q  <= 1'b0;
      end else if (fire) begin
        cnt_q <= CW'(PULSE_CYCLES);
        hi_q  <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        hi_q  <= (cnt_q > CW'(1));
      end else begin
        hi_q  <= 1'b0;
      end
    end
  end

  assign lat = lat_q;
  assign hi  = hi_q;

  // R5: strong pullup never on while latch commands the pulldown
  assert_no_fight_R5: assert property (@(posedge clk) disable iff (rst)
    !(hi_q && !lat_q));
  // R3: pulse ends only after its count is used up or the latch is cleared
  assert_pulse_end_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_q) |-> (!lat_q || $past(cnt_q) == CW'(1)));
  // R6: an AND on a set latch never restarts the pulse
  assert_and_nofire_R6: assert property (@(posedge clk) disable iff (rst)
    (op == QB_ANDM && lat_q && !hi_q) |=> !hi_q);
endmodule

// File: rtl/qb_port.sv
module qb_port
  import qbport_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 25,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op_code,
  input  logic [WIDTH-1:0] op_mask,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] drv_low,
  output logic [WIDTH-1:0] drv_high,
  output logic [WIDTH-1:0] drv_weak
);
  qb_op_e op;
  assign op = qb_op_e'(op_code);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    qb_bit_cell #(.PULSE_CYCLES(PULSE_CYCLES)) u_cell (
      .clk  (clk),
      .rst  (rst),
      .op   (op),
      .mask (op_mask[i]),
      .lat  (drv_weak[i]),
      .hi   (drv_high[i])
    );
  end

  assign drv_low = ~drv_weak;

  qb_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (rd_data)
  );

  // R2: load places the mask in the latch
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (op == QB_LOAD) |=> (drv_weak == $past(op_mask) && drv_high == $past(op_mask)));
  // R6: and clears masked-out bits only
  assert_and_R6: assert property (@(posedge clk) disable iff (rst)
    (op == QB_ANDM) |=> (drv_weak == ($past(drv_weak) & $past(op_mask))));
  // R7: or sets masked bits and fires their pulse
  assert_or_R7: assert property (@(posedge clk) disable iff (rst)
    (op == QB_ORM) |=> (drv_weak == ($past(drv_weak) | $past(op_mask))
                        && (drv_high & $past(op_mask)) == $past(op_mask)));
  // R9: idle keeps the latch
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (op == QB_NOP) |=> $stable(drv_weak));
  // R5: never both strong devices on
  assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
    (drv_low & drv_high) == '0);
endmodule

// File: tb/qb_port_test.sv
module qb_port_test;
  localparam int W = 8;
  localparam int P = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_code = 2'b00;
  logic [W-1:0] op_mask = '0;
  logic [W-1:0] ext = '1;
  logic [W-1:0] pin_in, rd_data, drv_low, drv_high, drv_weak;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic [W-1:0] mlat, ms1, ms2;
  int mcnt [W];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign pin_in = ext & ~drv_low;

  qb_port #(.WIDTH(W), .PULSE_CYCLES(P), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .op_code(op_code), .op_mask(op_mask),
    .pin_in(pin_in), .rd_data(rd_data), .drv_low(drv_low),
    .drv_high(drv_high), .drv_weak(drv_weak)
  );

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b01:   return "R2";
      2'b10:   return "R6";
      2'b11:   return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [W-1:0] model_hi();
    logic [W-1:0] h;
    for (int i = 0; i < W; i++) h[i] = (mcnt[i] != 0);
    return h;
  endfunction

  // one cycle: drive at a falling edge, update the model, check at the next falling edge
  task automatic step(input logic [1:0] op, input logic [W-1:0] m, input logic [W-1:0] ex);
    logic [W-1:0] nl;
    op_code = op; op_mask = m; ext = ex;
    ms2 = ms1;
    ms1 = ex & mlat;
    case (op)
      2'b01:   nl = m;
      2'b10:   nl = mlat & m;
      2'b11:   nl = mlat | m;
      default: nl = mlat;
    endcase
    for (int i = 0; i < W; i++) begin
      if (!nl[i]) mcnt[i] = 0;
      else if (!mlat[i] || ((op == 2'b01 || op == 2'b11) && m[i])) mcnt[i] = P;
      else if (mcnt[i] > 0) mcnt[i] = mcnt[i] - 1;
    end
    mlat = nl;
    @(negedge clk);
    chk(op_tag(op), "drv_weak", drv_weak, mlat);
    chk(op_tag(op), "drv_low", drv_low, ~mlat);
    chk("R3", "drv_high", drv_high, model_hi());
    chk("R5", "low&high", drv_low & drv_high, '0);
    chk("R8", "rd_data", rd_data, ms2);
  endtask

  task automatic idle(input int n, input logic [W-1:0] ex);
    for (int k = 0; k < n; k++) step(2'b00, W'($urandom), ex);
  endtask

  initial begin
    void'($urandom(32'd4321));
    for (int i = 0; i < W; i++) mcnt[i] = 0;
    mlat = '1; ms1 = '1; ms2 = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "weak after reset", drv_weak, '1);
    chk("R1", "low after reset", drv_low, '0);
    chk("R1", "high after reset", drv_high, '0);
    chk("R1", "rd after reset", rd_data, '1);

    step(2'b01, 8'h5A, '1);
    chk("R2", "latch load", drv_weak, 8'h5A);
    idle(P + 1, '1);
    chk("R3", "pulse done", drv_high, 8'h00);

    // R3 exact pulse length on bit 0
    step(2'b01, 8'h00, '1);
    step(2'b01, 8'h01, '1);
    idle(P - 1, '1);
    chk("R3", "last pulse cycle", drv_high, 8'h01);
    idle(1, '1);
    chk("R3", "pulse over", drv_high, 8'h00);

    // R4 retrigger during pulse
    step(2'b01, 8'h01, '1);
    idle(3, '1);
    step(2'b01, 8'h01, '1);
    idle(P - 1, '1);
    chk("R4", "restarted pulse still on", drv_high, 8'h01);
    idle(1, '1);
    chk("R4", "restarted pulse over", drv_high, 8'h00);

    // R5 cancel by writing 0
    step(2'b01, 8'h01, '1);
    step(2'b01, 8'h00, '1);
    chk("R5", "pulse cancelled", drv_high, 8'h00);
    chk("R5", "pulldown on", drv_low, 8'hFF);

    // R6 and: no pulse
    step(2'b01, 8'hFF, '1);
    idle(P + 1, '1);
    step(2'b10, 8'hF0, '1);
    chk("R6", "and latch", drv_weak, 8'hF0);
    chk("R6", "and no pulse", drv_high, 8'h00);

    // R7 or: pulse on masked bits
    step(2'b11, 8'h13, '1);
    chk("R7", "or latch", drv_weak, 8'hF3);
    chk("R7", "or pulse", drv_high, 8'h13);

    // R9 idle keeps latch
    idle(2, '1);
    chk("R9", "idle latch", drv_weak, 8'hF3);

    // R8 read of pins: outside 0 on latched-1 lines, latched-0 lines read 0
    step(2'b01, 8'hFF, 8'hA5);
    idle(2, 8'hA5);
    chk("R8", "outside zeros read", rd_data, 8'hA5);
    step(2'b01, 8'h0F, 8'hFF);
    idle(2, 8'hFF);
    chk("R8", "latched zeros read", rd_data, 8'h0F);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [1:0] op;
      op = ($urandom % 2 == 0) ? 2'b00 : 2'($urandom);
      step(op, W'($urandom), ($urandom % 3 == 0) ? W'($urandom) : '1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule